// File: doc/BRIEF.md
# Frame Transmit Control Sequencer

This block sends one framed packet out of a shared byte buffer. The buffer is reached through a request/acknowledge memory port that an arbiter outside this block owns. A CPU places payload bytes in the buffer and writes a byte count into a length/status slot. The CPU also pulses `lenRegWr`. The sequencer then reads the count back from the buffer. If the count is legal and the bit clock is running, it walks the payload and hands bytes one at a time to an external bit serializer. The order is an opening flag, the payload, the two checksum bytes, and a closing flag. It then overwrites the slot with a completion code and raises an interrupt.

A CRC16 engine outside the block is cleared before the frame and stepped once per payload byte. The serializer takes the same byte bus. The sequencer only fetches the finished checksum from the engine.

The sequencer also keeps a clock-status byte in the buffer that mirrors whether the bit clock is present. Every change of the clock is written back and signalled with an interrupt. When the CPU writes to that slot (pulse on `clkRegWr`), the sequencer restores the true status without an interrupt.

Top module: `tx_frame_seq`

## Requirements
- R1: After reset, `memReq`, `serValid`, `crcClr`, `crcEn` and `txIrq` are all low.
- R2: On a `lenRegWr` pulse the sequencer reads buffer offset 0xFF. A value N from 1 to 253 starts a packet whose payload is read from offsets 0 through N-1, in rising order.
- R3: A length value of 0x00, 0xFE or 0xFF starts nothing. No byte reaches the serializer, no interrupt is raised and offset 0xFF is not rewritten.
- R4: The bytes presented to the serializer, in order, are:
  - a flag marker, with `serFlag`=1 and `serData`=0x7E;
  - the N payload bytes, with `serFlag`=0;
  - `crcIn[15:8]`, then `crcIn[7:0]`;
  - a closing flag marker, with `serFlag`=1 and `serData`=0x7E.
- R5: `serValid` is a one-cycle pulse. Once a byte is presented, no further byte is presented until the serializer pulses `serNext`.
- R6: `crcClr` pulses exactly once per packet, together with the opening flag. `crcEn` pulses exactly once per payload byte, in the cycle that byte is presented.
- R7: After the closing flag is accepted, 0xFF is written to offset 0xFF. The write is followed by a one-cycle `txIrq` pulse.
- R8: Each change of `clkOk` leads to a write at offset 0xFE, followed by a one-cycle `txIrq` pulse. The value written is 0xFF while the clock is present and 0x00 while it is absent. While a packet is in progress, this write waits until the packet ends.
- R9: A `clkRegWr` pulse makes the sequencer rewrite the current clock status at offset 0xFE without asserting `txIrq`.
- R10: A start request whose length is read while `clkOk` is low sends nothing and leaves offset 0xFF unchanged.
- R11: A memory request holds `memReq`, `memAddr`, `memWe` and `memWrData` stable until the cycle in which `memAck` is high. Read data is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkOk | input | 1 | Bit clock present |
| clkRegWr | input | 1 | Pulse: CPU wrote the clock-status slot |
| lenRegWr | input | 1 | Pulse: CPU wrote the length/status slot |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Buffer offset |
| memWrData | output | 8 | Write data |
| memRdData | input | 8 | Read data, valid with `memAck` |
| memAck | input | 1 | One-cycle access completion |
| serValid | output | 1 | Byte presented to the serializer |
| serFlag | output | 1 | Presented byte is a flag marker |
| serData | output | 8 | Presented byte |
| serNext | input | 1 | Serializer ready for the next byte |
| crcClr | output | 1 | Clear CRC engine to its initial value |
| crcEn | output | 1 | Step CRC engine with `serData` |
| crcIn | input | 16 | Current CRC engine result |
| txIrq | output | 1 | One-cycle transmit interrupt |

## Verification
Packets of 1, 3 and 253 bytes, each with different payload contents, are compared byte by byte against a reference stream built from the buffer image. This separates off-by-one errors at both ends of the payload from errors in the checksum byte order. The three illegal lengths show whether the range decode is exact at its edges. A clock rise, a clock drop and a CPU write to the clock-status slot each test a different path. Together they show whether status writes and interrupts are tied to real changes only. A length written while the clock is absent, followed by a normal packet once the clock returns, shows that a refused start leaves no state behind.

// File: rtl/tx_frame_seq_pkg.sv
package tx_frame_seq_pkg;

  localparam int DATA_W = 8;
  localparam int CRC_W  = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_CLKWR, S_LENRD, S_OPEN, S_RD, S_PAY,
    S_HI, S_LO, S_CLOSE, S_WAIT, S_DONE
  } seqState_t;

  typedef struct packed {
    logic loadLen;
    logic clrIdx;
    logic incIdx;
    logic loadByte;
    logic latchClk;
  } seqCtl_t;

endpackage

// File: rtl/tx_frame_seq_dp.sv
module tx_frame_seq_dp
  import tx_frame_seq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int MAX_LEN = 253
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              clkOk,
  output logic [ADDR_W-1:0] idx,
  output logic [DATA_W-1:0] byteReg,
  output logic              idxLast,
  output logic              lenValid,
  output logic              clkChanged,
  output logic [DATA_W-1:0] clkByte
);

  localparam logic [DATA_W-1:0] MAX_L = DATA_W'(MAX_LEN);

  logic [DATA_W-1:0] lenReg;
  logic              clkPrev;
  logic              clkVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg  <= '0;
      idx     <= '0;
      byteReg <= '0;
      clkPrev <= 1'b0;
      clkVal  <= 1'b0;
    end else begin
      clkPrev <= clkOk;
      if (ctl.loadLen)  lenReg  <= memRdData;
      if (ctl.clrIdx)   idx     <= '0;
      else if (ctl.incIdx) idx  <= idx + ADDR_W'(1);
      if (ctl.loadByte) byteReg <= memRdData;
      if (ctl.latchClk) clkVal  <= clkOk;
    end
  end

  always_comb begin
    idxLast    = (idx + ADDR_W'(1)) == ADDR_W'(lenReg);
    lenValid   = (memRdData != '0) && (memRdData <= MAX_L);
    clkChanged = clkOk != clkPrev;
    clkByte    = clkVal ? '1 : '0;
  end

  // R2: the fetch index never runs past the loaded length
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lenReg == '0) || (ADDR_W'(lenReg) > idx));

endmodule

// File: rtl/tx_frame_seq_ctl.sv
module tx_frame_seq_ctl
  import tx_frame_seq_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                LEN_OFS   = 255,
  parameter int                CLK_OFS   = 254,
  parameter logic [DATA_W-1:0] FLAG_BYTE = 8'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkOk,
  input  logic              clkRegWr,
  input  logic              lenRegWr,
  input  logic              memAck,
  input  logic              serNext,
  input  logic [CRC_W-1:0]  crcIn,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] byteReg,
  input  logic              idxLast,
  input  logic              lenValid,
  input  logic              clkChanged,
  input  logic [DATA_W-1:0] clkByte,
  output seqCtl_t           ctl,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              serValid,
  output logic              serFlag,
  output logic [DATA_W-1:0] serData,
  output logic              crcClr,
  output logic              crcEn,
  output logic              txIrq
);

  localparam logic [ADDR_W-1:0] LEN_A = ADDR_W'(LEN_OFS);
  localparam logic [ADDR_W-1:0] CLK_A = ADDR_W'(CLK_OFS);
  localparam logic [DATA_W-1:0] DONE_CODE = '1;

  seqState_t state, stateNx, retState, retNx;
  logic lenPend, clkPend, clkLoud;
  logic busy, startLen, startClk;

  assign busy     = !(state inside {S_IDLE, S_CLKWR, S_LENRD});
  assign startClk = (state == S_IDLE) && clkPend;
  assign startLen = (state == S_IDLE) && !clkPend && lenPend;

  always_comb begin
    stateNx = state;
    retNx   = retState;
    unique case (state)
      S_IDLE:  if (clkPend) stateNx = S_CLKWR;
               else if (lenPend) stateNx = S_LENRD;
      S_CLKWR: if (memAck) stateNx = S_IDLE;
      S_LENRD: if (memAck) stateNx = (lenValid && clkOk) ? S_OPEN : S_IDLE;
      S_OPEN:  begin stateNx = S_WAIT; retNx = S_RD; end
      S_RD:    if (memAck) stateNx = S_PAY;
      S_PAY:   begin stateNx = S_WAIT; retNx = idxLast ? S_HI : S_RD; end
      S_HI:    begin stateNx = S_WAIT; retNx = S_LO; end
      S_LO:    begin stateNx = S_WAIT; retNx = S_CLOSE; end
      S_CLOSE: begin stateNx = S_WAIT; retNx = S_DONE; end
      S_WAIT:  if (serNext) stateNx = retState;
      S_DONE:  if (memAck) stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  always_comb begin
    ctl          = '0;
    ctl.latchClk = startClk;
    ctl.loadLen  = (state == S_LENRD) && memAck && lenValid && clkOk;
    ctl.clrIdx   = ctl.loadLen;
    ctl.loadByte = (state == S_RD) && memAck;
    ctl.incIdx   = (state == S_PAY) && !idxLast;

    memReq    = state inside {S_CLKWR, S_LENRD, S_RD, S_DONE};
    memWe     = state inside {S_CLKWR, S_DONE};
    memAddr   = (state == S_CLKWR) ? CLK_A : (state == S_RD) ? idx : LEN_A;
    memWrData = (state == S_CLKWR) ? clkByte : (state == S_DONE) ? DONE_CODE : '0;

    serValid = state inside {S_OPEN, S_PAY, S_HI, S_LO, S_CLOSE};
    serFlag  = state inside {S_OPEN, S_CLOSE};
    unique case (state)
      S_PAY:   serData = byteReg;
      S_HI:    serData = crcIn[CRC_W-1 -: DATA_W];
      S_LO:    serData = crcIn[DATA_W-1:0];
      S_OPEN,
      S_CLOSE: serData = FLAG_BYTE;
      default: serData = '0;
    endcase
    crcClr = state == S_OPEN;
    crcEn  = state == S_PAY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      retState <= S_IDLE;
      lenPend  <= 1'b0;
      clkPend  <= 1'b0;
      clkLoud  <= 1'b0;
      txIrq    <= 1'b0;
    end else begin
      state    <= stateNx;
      retState <= retNx;
      txIrq    <= memAck && ((state == S_DONE) || (state == S_CLKWR && clkLoud));

      if (lenRegWr && !busy) lenPend <= 1'b1;
      else if (startLen)     lenPend <= 1'b0;

      if (clkChanged) begin
        clkPend <= 1'b1;
        clkLoud <= 1'b1;
      end else if (clkRegWr) begin
        clkPend <= 1'b1;
      end else if (state == S_CLKWR && memAck) begin
        clkPend <= 1'b0;
        clkLoud <= 1'b0;
      end
    end
  end

  // R11: request and its qualifiers hold until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWrData)));

  // R5: a byte is presented for a single cycle only
  p_valid_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    serValid |=> !serValid);

  // R5: while waiting for the serializer, nothing new is presented
  p_next_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && !serNext) |=> !serValid);

  // R6: the clear is never immediately followed by a CRC step
  p_clr_then_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    crcClr |=> !crcEn);

  // R7/R8: interrupt is a single-cycle pulse
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tx_frame_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAX_LEN   = 253,
  parameter int LEN_OFS   = 255,
  parameter int CLK_OFS   = 254,
  parameter int FLAG_CODE = 126
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkOk,
  input  logic              clkRegWr,
  input  logic              lenRegWr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  input  logic              memAck,
  output logic              serValid,
  output logic              serFlag,
  output logic [7:0]        serData,
  input  logic              serNext,
  output logic              crcClr,
  output logic              crcEn,
  input  logic [15:0]       crcIn,
  output logic              txIrq
);

  localparam logic [DATA_W-1:0] FLAG_BYTE = DATA_W'(FLAG_CODE);

  seqCtl_t           ctl;
  logic [ADDR_W-1:0] idx;
  logic [DATA_W-1:0] byteReg;
  logic [DATA_W-1:0] clkByte;
  logic              idxLast, lenValid, clkChanged;

  tx_frame_seq_dp #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdData(memRdData), .clkOk(clkOk),
    .idx(idx), .byteReg(byteReg), .idxLast(idxLast), .lenValid(lenValid),
    .clkChanged(clkChanged), .clkByte(clkByte)
  );

  tx_frame_seq_ctl #(.ADDR_W(ADDR_W), .LEN_OFS(LEN_OFS), .CLK_OFS(CLK_OFS),
                     .FLAG_BYTE(FLAG_BYTE)) u_ctl (
    .clk(clk), .rstN(rstN), .clkOk(clkOk), .clkRegWr(clkRegWr),
    .lenRegWr(lenRegWr), .memAck(memAck), .serNext(serNext), .crcIn(crcIn),
    .idx(idx), .byteReg(byteReg), .idxLast(idxLast), .lenValid(lenValid),
    .clkChanged(clkChanged), .clkByte(clkByte), .ctl(ctl),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .serValid(serValid), .serFlag(serFlag), .serData(serData),
    .crcClr(crcClr), .crcEn(crcEn), .txIrq(txIrq)
  );

endmodule

// File: tb/tx_frame_seq_bench.sv
`timescale 1ns/1ps
module tx_frame_seq_bench;

  localparam logic [15:0] CRC_INIT = 16'h0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkOk = 1'b0, clkRegWr = 1'b0, lenRegWr = 1'b0;
  logic memReq, memWe, memAck = 1'b0;
  logic [7:0] memAddr, memWrData, memRdData = 8'h00;
  logic serValid, serFlag, serNext = 1'b0;
  logic [7:0] serData;
  logic crcClr, crcEn, txIrq;
  logic [15:0] crcReg = CRC_INIT;

  always #2 clk = ~clk;

  tx_frame_seq u_tx_frame_seq (
    .clk(clk), .rstN(rstN), .clkOk(clkOk), .clkRegWr(clkRegWr), .lenRegWr(lenRegWr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memAck(memAck), .serValid(serValid), .serFlag(serFlag),
    .serData(serData), .serNext(serNext), .crcClr(crcClr), .crcEn(crcEn),
    .crcIn(crcReg), .txIrq(txIrq)
  );

  int checks = 0, fails = 0;
  logic [7:0] mem [256];
  logic [8:0] expQ [$];
  int readLog [$];
  int irqCnt = 0, byteCnt = 0, clrCnt = 0, enCnt = 0;
  int reqViol = 0, hsViol = 0;
  int ackWait = 0, nextCnt = 0;
  bit pendNext = 0, prevReq = 0, prevAck = 0, prevWe = 0;
  logic [7:0] prevAddr = 0, prevWd = 0;

  function automatic logic [15:0] crcStep(logic [15:0] c, logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ b[i];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference models of memory, serializer and CRC engine, per clock
  always @(negedge clk) begin
    if (rstN) begin
      if (prevReq && !prevAck && memReq &&
          (memAddr != prevAddr || memWe != prevWe || memWrData != prevWd)) reqViol++;
      prevReq = memReq; prevAck = memAck; prevAddr = memAddr;
      prevWe = memWe; prevWd = memWrData;

      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        ackWait++;
        if (ackWait >= 2) begin
          ackWait = 0;
          memAck = 1'b1;
          if (memWe) mem[memAddr] = memWrData;
          else begin
            memRdData = mem[memAddr];
            readLog.push_back(int'(memAddr));
          end
        end
      end

      serNext = 1'b0;
      if (pendNext) begin
        if (nextCnt == 0) begin serNext = 1'b1; pendNext = 0; end
        else nextCnt--;
      end
      if (serValid) begin
        if (pendNext) hsViol++;
        byteCnt++;
        if (expQ.size() == 0)
          chk(0, "R3/R10", "unexpected serializer byte", int'({serFlag, serData}), 0);
        else begin
          logic [8:0] e;
          e = expQ.pop_front();
          chk({serFlag, serData} == e, "R4", "serializer byte {flag,data}",
              int'({serFlag, serData}), int'(e));
        end
        pendNext = 1; nextCnt = 2;
      end

      if (crcClr) begin clrCnt++; crcReg = CRC_INIT; end
      else if (crcEn) begin enCnt++; crcReg = crcStep(crcReg, serData); end
      if (txIrq) irqCnt++;
    end
  end

  task automatic pulseLen(logic [7:0] v);
    @(negedge clk); mem[8'hFF] = v; lenRegWr = 1'b1;
    @(negedge clk); lenRegWr = 1'b0;
  endtask

  task automatic sendPkt(int n, int seed);
    logic [15:0] c;
    int irq0, clr0, en0;
    c = CRC_INIT;
    readLog.delete();
    expQ.push_back({1'b1, 8'h7E});
    for (int i = 0; i < n; i++) begin
      mem[i] = 8'((i * 37 + seed) ^ (i >> 2));
      c = crcStep(c, mem[i]);
      expQ.push_back({1'b0, mem[i]});
    end
    expQ.push_back({1'b0, c[15:8]});
    expQ.push_back({1'b0, c[7:0]});
    expQ.push_back({1'b1, 8'h7E});
    irq0 = irqCnt; clr0 = clrCnt; en0 = enCnt;
    pulseLen(8'(n));
    for (int t = 0; t < 20000 && irqCnt == irq0; t++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R4", "bytes left unsent", expQ.size(), 0);
    chk(readLog.size() == n + 1, "R2", "read count", readLog.size(), n + 1);
    for (int i = 0; i < readLog.size() && i <= n; i++)
      chk(readLog[i] == ((i == 0) ? 255 : i - 1), "R2", "read address order",
          readLog[i], (i == 0) ? 255 : i - 1);
    chk(clrCnt - clr0 == 1, "R6", "crcClr pulses", clrCnt - clr0, 1);
    chk(enCnt - en0 == n, "R6", "crcEn pulses", enCnt - en0, n);
    chk(mem[8'hFF] == 8'hFF, "R7", "completion code", mem[8'hFF], 8'hFF);
    chk(irqCnt - irq0 == 1, "R7", "completion irq", irqCnt - irq0, 1);
    expQ.delete();
  endtask

  task automatic tryIgnored(logic [7:0] v, string req);
    int irq0, b0;
    irq0 = irqCnt; b0 = byteCnt;
    pulseLen(v);
    repeat (60) @(negedge clk);
    chk(byteCnt == b0, req, "bytes sent", byteCnt - b0, 0);
    chk(irqCnt == irq0, req, "irq count", irqCnt - irq0, 0);
    chk(mem[8'hFF] == v, req, "length slot unchanged", mem[8'hFF], v);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({memReq, serValid, crcClr, crcEn, txIrq} == 5'b0, "R1", "outputs in reset",
        {memReq, serValid, crcClr, crcEn, txIrq}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk({memReq, serValid, crcClr, crcEn, txIrq} == 5'b0, "R1", "outputs after reset",
        {memReq, serValid, crcClr, crcEn, txIrq}, 0);

    // R8 clock appears
    clkOk = 1'b1;
    repeat (20) @(negedge clk);
    chk(mem[8'hFE] == 8'hFF, "R8", "clock status present", mem[8'hFE], 8'hFF);
    chk(irqCnt == 1, "R8", "irq on clock rise", irqCnt, 1);

    // R9 silent restore
    mem[8'hFE] = 8'h55; clkRegWr = 1'b1;
    @(negedge clk); clkRegWr = 1'b0;
    repeat (20) @(negedge clk);
    chk(mem[8'hFE] == 8'hFF, "R9", "status restored", mem[8'hFE], 8'hFF);
    chk(irqCnt == 1, "R9", "no irq on silent restore", irqCnt, 1);

    // R2 R4 R6 R7 packets of several lengths
    sendPkt(3, 5);
    sendPkt(1, 200);
    sendPkt(253, 17);

    // R3 illegal length values
    tryIgnored(8'h00, "R3");
    tryIgnored(8'hFE, "R3");
    tryIgnored(8'hFF, "R3");

    // R8 clock drop
    begin
      int irq0;
      irq0 = irqCnt;
      @(negedge clk); clkOk = 1'b0;
      repeat (20) @(negedge clk);
      chk(mem[8'hFE] == 8'h00, "R8", "clock status absent", mem[8'hFE], 0);
      chk(irqCnt - irq0 == 1, "R8", "irq on clock drop", irqCnt - irq0, 1);
    end

    // R10 start refused without clock
    tryIgnored(8'h05, "R10");

    // clock back, normal packet still works
    @(negedge clk); clkOk = 1'b1;
    repeat (20) @(negedge clk);
    sendPkt(2, 99);

    // R5 R11 protocol counters
    chk(hsViol == 0, "R5", "bytes presented before serNext", hsViol, 0);
    chk(reqViol == 0, "R11", "request changed before ack", reqViol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule